// File: doc/BRIEF.md
# Divided-Clock Generator with Slow-Down Select

This block turns a fast oscillator-derived clock into the system clock of a chip. A post-divider splits the incoming fast clock by a factor picked through a 3-bit code. The code-to-factor mapping is not binary. Two of the eight codes give odd factors. Those factors produce an uneven duty cycle, so the block raises a warning flag while either one is selected. A second flag rises when the fast clock, divided by the chosen factor, would still exceed a ceiling set by parameters.

A cascaded slow-down divider divides the post-divided clock again, by any whole number from 1 to 32. A 5-bit reload value sets that number, and the value 0 stands for 32. A slow-down enable chooses which clock drives the system clock: the post-divided clock or the slowed one. The switch between the two happens only when both clocks are low, so a change of the enable never cuts a pulse short.

All logic runs in the fast clock domain. Both clock outputs come straight from flip-flops.

Top module: `sysclk_divmux`

## Requirements
- R1: The divided clock `pll_clk` has a period of K cycles of `vco_clk`. The factor K comes from `kdiv_code`: 000 gives 2, 001 gives 16, 010 gives 4, 011 gives 5, 100 gives 6, 101 gives 8, 110 gives 9 and 111 gives 10.
- R2: Each period of `pll_clk` has floor(K/2) high cycles followed by K-floor(K/2) low cycles. An even K therefore gives an exact 50 % duty cycle.
- R3: `odd_flag` is 1 exactly when the code applied at the previous clock edge is 011 or 110. It reaches the port one cycle after the code changes.
- R4: `overfreq_flag` is 1, one cycle after the code is applied, when VCO_KHZ > FMAX_KHZ*K. With the default parameters (160000 and 40000) only code 000 sets it.
- R5: With `slow_en` = 1, the period of `sys_clk` is K*N cycles. N equals `slow_reload` for values 1 to 31, and a reload of 0 means N = 32. Every edge of the slow clock coincides with an edge of `pll_clk`.
- R6: For N of 2 or more, the slow clock is high for floor(N/2)*K cycles and then low for the rest of its period. For N = 1 it is identical to `pll_clk`.
- R7: With `slow_en` = 0 and the selection settled, `sys_clk` equals `pll_clk` cycle for cycle.
- R8: The selection changes only in a cycle where both `pll_clk` and the slow clock are low. No high or low run of `sys_clk` is shorter than floor(K/2) cycles, and after the switch `sys_clk` takes on the waveform of the newly selected clock.
- R9: While `rst_n` is low, `pll_clk`, `sys_clk`, `odd_flag` and `overfreq_flag` are 0. On the first rising edge of `vco_clk` after release, both `pll_clk` and `sys_clk` go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kdiv_code | input | 3 | Post-divider factor code |
| slow_reload | input | 5 | Slow-down divide value (0 means 32) |
| slow_en | input | 1 | Selects the slowed clock for sys_clk |
| pll_clk | output | 1 | Post-divided clock |
| sys_clk | output | 1 | Selected system clock |
| odd_flag | output | 1 | Odd, not-recommended factor selected |
| overfreq_flag | output | 1 | Divided clock exceeds the frequency ceiling |

## Verification
Both clocks rise on the first edge after reset release, so each waveform is measured from a known start. The bench samples on falling edges and counts the high and low runs of `pll_clk` and `sys_clk`. These are compared with K-based and K*N-based lengths pushed by the driver. The flags are registered and therefore due one cycle after a code change; the bench changes the code at a falling edge and samples at the next falling edge. A change of `slow_en` takes effect only at the next cycle in which both clocks are low, which can be up to a full slow period later. For that reason the bench checks the minimum run length while it toggles the enable, and checks the new waveform only after waiting longer than one slow period.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
    localparam int KMAX   = 16;
    localparam int KW     = $clog2(KMAX + 1);
    localparam int CODE_W = 3;

    // non-binary code-to-factor mapping
    function automatic logic [KW-1:0] code_factor(input logic [CODE_W-1:0] c);
        logic [KW-1:0] k;
        case (c)
            3'b000:  k = KW'(2);
            3'b001:  k = KW'(16);
            3'b010:  k = KW'(4);
            3'b011:  k = KW'(5);
            3'b100:  k = KW'(6);
            3'b101:  k = KW'(8);
            3'b110:  k = KW'(9);
            default: k = KW'(10);
        endcase
        return k;
    endfunction
endpackage

// File: rtl/sysclk_postdiv.sv
module sysclk_postdiv
    import sysclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              pll_q,
    output logic              pll_nxt,
    output logic              wrap_nxt
);
    typedef struct packed {
        logic [KW-1:0] cnt;
        logic          lvl;
    } pd_state_t;

    pd_state_t st_d, st_q;
    logic [KW-1:0] k;
    logic [KW-1:0] half;

    always_comb begin
        k    = code_factor(code);
        half = k >> 1;
        st_d = st_q;
        if (st_q.cnt >= k - KW'(1))
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + KW'(1);
        st_d.lvl = (st_d.cnt < half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
            st_q.lvl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pll_q    = st_q.lvl;
    assign pll_nxt  = st_d.lvl;
    assign wrap_nxt = (st_d.cnt == '0);
endmodule

// File: rtl/sysclk_slowdiv.sv
module sysclk_slowdiv #(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] reload,
    input  logic          pll_nxt,
    input  logic          wrap_nxt,
    output logic          slow_q,
    output logic          slow_nxt
);
    localparam int NW = RW + 1;

    typedef struct packed {
        logic [RW-1:0] pcnt;
        logic          lvl;
    } sd_state_t;

    sd_state_t st_d, st_q;
    logic [NW-1:0] n_eff;

    always_comb begin
        n_eff = (reload == '0) ? NW'(1 << RW) : {1'b0, reload};
        st_d  = st_q;
        if (wrap_nxt) begin
            if ({1'b0, st_q.pcnt} >= n_eff - NW'(1))
                st_d.pcnt = '0;
            else
                st_d.pcnt = st_q.pcnt + RW'(1);
        end
        if (n_eff == NW'(1))
            st_d.lvl = pll_nxt;
        else
            st_d.lvl = ({1'b0, st_d.pcnt} < (n_eff >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pcnt <= '1;
            st_q.lvl  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slow_q   = st_q.lvl;
    assign slow_nxt = st_d.lvl;
endmodule

// File: rtl/sysclk_glitchsw.sv
module sysclk_glitchsw (
    input  logic clk,
    input  logic rst_n,
    input  logic want_slow,
    input  logic pll_q,
    input  logic slow_q,
    input  logic pll_nxt,
    input  logic slow_nxt,
    output logic sys_q,
    output logic sel_q
);
    typedef struct packed {
        logic sel;
        logic out;
    } sw_state_t;

    sw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if ((want_slow != st_q.sel) && !pll_q && !slow_q)
            st_d.sel = want_slow;
        st_d.out = st_d.sel ? slow_nxt : pll_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sys_q = st_q.out;
    assign sel_q = st_q.sel;
endmodule

// File: rtl/sysclk_divmux.sv
module sysclk_divmux
    import sysclk_pkg::*;
#(
    parameter int VCO_KHZ  = 160000,
    parameter int FMAX_KHZ = 40000,
    parameter int RELOAD_W = 5
) (
    input  logic                vco_clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   kdiv_code,
    input  logic [RELOAD_W-1:0] slow_reload,
    input  logic                slow_en,
    output logic                pll_clk,
    output logic                sys_clk,
    output logic                odd_flag,
    output logic                overfreq_flag
);
    typedef struct packed {
        logic odd;
        logic ovr;
    } flag_state_t;

    flag_state_t fl_d, fl_q;
    logic [KW-1:0] k_sel;
    logic pll_nxt, wrap_nxt, slow_q, slow_nxt, sel_q;

    sysclk_postdiv u_postdiv (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .code     (kdiv_code),
        .pll_q    (pll_clk),
        .pll_nxt  (pll_nxt),
        .wrap_nxt (wrap_nxt)
    );

    sysclk_slowdiv #(.RW(RELOAD_W)) u_slowdiv (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .reload   (slow_reload),
        .pll_nxt  (pll_nxt),
        .wrap_nxt (wrap_nxt),
        .slow_q   (slow_q),
        .slow_nxt (slow_nxt)
    );

    sysclk_glitchsw u_glitchsw (
        .clk       (vco_clk),
        .rst_n     (rst_n),
        .want_slow (slow_en),
        .pll_q     (pll_clk),
        .slow_q    (slow_q),
        .pll_nxt   (pll_nxt),
        .slow_nxt  (slow_nxt),
        .sys_q     (sys_clk),
        .sel_q     (sel_q)
    );

    always_comb begin
        k_sel  = code_factor(kdiv_code);
        fl_d.odd = k_sel[0];
        fl_d.ovr = (VCO_KHZ > FMAX_KHZ * int'(k_sel));
    end

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign odd_flag      = fl_q.odd;
    assign overfreq_flag = fl_q.ovr;
endmodule

// File: rtl/sysclk_divmux_chk.sv
module sysclk_divmux_chk #(
    parameter int RELOAD_W = 5
) (
    input logic                vco_clk,
    input logic                rst_n,
    input logic [2:0]          kdiv_code,
    input logic [RELOAD_W-1:0] slow_reload,
    input logic                pll_clk,
    input logic                sys_clk,
    input logic                slow_clk,
    input logic                sel,
    input logic                odd_flag
);
    // R3
    odd_code_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
        $past(rst_n) |-> (odd_flag == $past(kdiv_code == 3'b011 || kdiv_code == 3'b110)));

    // R8
    switch_low_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (sel != $past(sel)) |-> (!$past(pll_clk) && !$past(slow_clk)));

    // R7
    follow_pll_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
        !sel |-> (sys_clk == pll_clk));

    // R5
    slow_aligned_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (slow_clk != $past(slow_clk)) |-> (pll_clk != $past(pll_clk)));

    // R6
    unity_slow_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (sel && slow_reload == RELOAD_W'(1) && $stable(slow_reload)) |-> (sys_clk == pll_clk));
endmodule

bind sysclk_divmux sysclk_divmux_chk #(.RELOAD_W(RELOAD_W)) u_chk (
    .vco_clk     (vco_clk),
    .rst_n       (rst_n),
    .kdiv_code   (kdiv_code),
    .slow_reload (slow_reload),
    .pll_clk     (pll_clk),
    .sys_clk     (sys_clk),
    .slow_clk    (slow_q),
    .sel         (sel_q),
    .odd_flag    (odd_flag)
);

// File: tb/sysclk_divmux_bench.sv
module sysclk_divmux_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] kdiv_code = 3'b000;
    logic [4:0] slow_reload = 5'd1;
    logic       slow_en = 1'b0;
    logic       pll_clk, sys_clk, odd_flag, overfreq_flag;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        int ph; int pl; int sh; int sl;
        bit odd; bit ovr;
    } exp_t;

    exp_t q[$];
    event go, done;

    always #5 clk = ~clk;

    sysclk_divmux u_sysclk_divmux (
        .vco_clk(clk), .rst_n(rst_n), .kdiv_code(kdiv_code),
        .slow_reload(slow_reload), .slow_en(slow_en),
        .pll_clk(pll_clk), .sys_clk(sys_clk),
        .odd_flag(odd_flag), .overfreq_flag(overfreq_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int factor_of(input logic [2:0] c);
        case (c)
            3'b000: return 2;  3'b001: return 16; 3'b010: return 4;
            3'b011: return 5;  3'b100: return 6;  3'b101: return 8;
            3'b110: return 9;  default: return 10;
        endcase
    endfunction

    task automatic measure(input bit use_sys, output int hi, output int lo);
        bit prev, cur, found;
        int guard;
        hi = 0; lo = 0; guard = 0; found = 0;
        @(negedge clk); prev = use_sys ? sys_clk : pll_clk;
        while (!found && guard < 1500) begin
            @(negedge clk); cur = use_sys ? sys_clk : pll_clk;
            found = !prev && cur; prev = cur; guard++;
        end
        if (!found) return;
        while (cur && guard < 3000) begin
            hi++; @(negedge clk); cur = use_sys ? sys_clk : pll_clk; guard++;
        end
        while (!cur && guard < 3000) begin
            lo++; @(negedge clk); cur = use_sys ? sys_clk : pll_clk; guard++;
        end
    endtask

    task automatic run_cfg(input logic [2:0] c, input logic [4:0] r, input bit en);
        exp_t e;
        int k, n;
        @(negedge clk);
        rst_n = 1'b0; kdiv_code = c; slow_reload = r; slow_en = en;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        k = factor_of(c);
        n = (r == 0) ? 32 : int'(r);
        e.ph = k / 2; e.pl = k - k / 2;
        if (!en || n == 1) begin
            e.sh = e.ph; e.sl = e.pl;
        end else begin
            e.sh = (n / 2) * k; e.sl = n * k - e.sh;
        end
        e.odd = (k % 2) == 1;
        e.ovr = (160000 > 40000 * k);
        q.push_back(e);
        ->go;
        @(done);
    endtask

    // monitor: pops expected items and compares against measured waveforms
    initial begin
        forever begin
            exp_t e;
            int hi, lo;
            @(go);
            e = q.pop_front();
            measure(1'b0, hi, lo);
            chk("R1/R2 pll high", hi, e.ph);
            chk("R1/R2 pll low", lo, e.pl);
            chk("R3 odd_flag", odd_flag, e.odd);
            chk("R4 overfreq_flag", overfreq_flag, e.ovr);
            measure(1'b1, hi, lo);
            chk("R5/R6/R7 sys high", hi, e.sh);
            chk("R5/R6/R7 sys low", lo, e.sl);
            ->done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int run, minrun;
        bit prev;
        int hi, lo;

        // R9 reset state and first edge
        kdiv_code = 3'b011;
        repeat (3) @(negedge clk);
        chk("R9 pll in reset", pll_clk, 0);
        chk("R9 sys in reset", sys_clk, 0);
        chk("R9 odd in reset", odd_flag, 0);
        chk("R9 ovr in reset", overfreq_flag, 0);
        slow_en = 1'b1; slow_reload = 5'd4;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 pll first edge", pll_clk, 1);
        chk("R9 sys first edge", sys_clk, 1);

        // R1 R2 R3 R4 R7: every code, slow path off
        for (int c = 0; c < 8; c++) run_cfg(3'(c), 5'd5, 1'b0);
        // R5 R6: slow path
        run_cfg(3'b010, 5'd0, 1'b1);   // N=32
        run_cfg(3'b010, 5'd1, 1'b1);   // N=1
        run_cfg(3'b010, 5'd3, 1'b1);
        run_cfg(3'b001, 5'd31, 1'b1);
        run_cfg(3'b011, 5'd2, 1'b1);
        run_cfg(3'b100, 5'd7, 1'b1);

        // R8: toggling enable never yields a short run
        @(negedge clk);
        rst_n = 1'b0; kdiv_code = 3'b010; slow_reload = 5'd3; slow_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); prev = sys_clk; run = 0; minrun = 1000;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (i % 37 == 36) slow_en = ~slow_en;
            if (sys_clk != prev) begin
                if (run > 0 && run < minrun) minrun = run;
                run = 1; prev = sys_clk;
            end else if (run > 0) run++;
        end
        chk("R8 min run >= 2", int'(minrun >= 2), 1);
        slow_en = 1'b1;
        repeat (40) @(negedge clk);
        measure(1'b1, hi, lo);
        chk("R8 after switch to slow high", hi, 4);
        chk("R8 after switch to slow low", lo, 8);
        slow_en = 1'b0;
        repeat (40) @(negedge clk);
        measure(1'b1, hi, lo);
        chk("R8 after switch to pll high", hi, 2);
        chk("R8 after switch to pll low", lo, 2);

        // R3 R4 timing: flags due one cycle after a code change
        kdiv_code = 3'b110;
        @(negedge clk);
        chk("R3 odd one cycle later", odd_flag, 1);
        chk("R4 ovr clear for 9", overfreq_flag, 0);
        kdiv_code = 3'b000;
        @(negedge clk);
        chk("R3 odd cleared", odd_flag, 0);
        chk("R4 ovr set for 2", overfreq_flag, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule